// File: doc/BRIEF.md
# Oversampling Conversion Sequencer

This block sequences conversions for an eight-channel acquisition core whose channels are split into two groups of four. It watches two start inputs, one per group, and asks an abstract sample source for data by pulsing one trigger strobe per group. For every channel it adds up the returned 16-bit two's-complement samples. When the conversion ends, it writes the scaled average into eight result registers. A busy output is high for the whole conversion.

A 3-bit select picks the averaging ratio. The select is taken only at the moment busy drops, and the value taken governs the next conversion. When averaging is on, the start edge of the first group produces the first trigger for all eight channels. The block then issues the remaining triggers itself, each one after every sample of the previous round has come back.

When averaging is off, each group is triggered by its own start edge. The conversion counts as begun once both groups have started. If the second group does not start within a parameter-set number of cycles, the conversion finishes with only the group that was sampled.

Top module: `os_conv_seq`

## Requirements
- R1: After reset, busy_o, trig_a_o, trig_b_o and bad_cfg_o are low, every result lane is zero, and the latched ratio is 1 (no averaging).
- R2: The select code c is decoded as follows. Codes 0 to 6 give a ratio of 2^c. Code 7 gives a ratio of 1 and sets bad_cfg_o high. bad_cfg_o keeps the validity of the last code taken.
- R3: os_sel_i is taken only on the clock edge where busy_o falls, and it sets the ratio of the following conversion. Changes to os_sel_i at any other time have no effect.
- R4: With a ratio N greater than 1, a rising edge on start_a_i pulses trig_a_o and trig_b_o together. Each pulse lasts one cycle. The block then issues N-1 further pulse pairs on its own, each one after both groups have returned the previous samples, so each strobe pulses exactly N times per conversion.
- R5: busy_o stays high until the last sample round has been received. The result lanes change only on the clock edge where busy_o falls.
- R6: The result for each channel is the 23-bit signed sum of its N samples, arithmetically shifted right by log2(N). The shift truncates toward minus infinity, and the low 16 bits are kept as two's complement.
- R7: With a ratio of 1, start_a_i triggers only channels 0-3 (lanes 0..3) and start_b_i triggers only channels 4-7 (lanes 4..7). busy_o rises only after both groups have started.
- R8: A start edge for a group that has already been triggered in the current conversion, or any start edge while busy_o is high, produces no trigger pulse.
- R9: With a ratio of 1, suppose only one group starts. If the other group does not start within WAIT_LIMIT cycles, busy_o rises and the conversion completes. The lanes of the missing group keep their previous values.
- R10: With a ratio greater than 1, a start_b_i edge alone triggers nothing and leaves busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_a_i | input | 1 | Start level for group A (lanes 0..3); its rising edge counts |
| start_b_i | input | 1 | Start level for group B (lanes 4..7); its rising edge counts |
| os_sel_i | input | 3 | Averaging ratio code |
| smp_valid_a_i | input | 1 | Group A samples present on smp_data_i |
| smp_valid_b_i | input | 1 | Group B samples present on smp_data_i |
| smp_data_i | input | 128 | Eight 16-bit samples; lane k at bits 16k+15..16k |
| trig_a_o | output | 1 | One-cycle sample request for group A |
| trig_b_o | output | 1 | One-cycle sample request for group B |
| busy_o | output | 1 | Conversion in progress |
| bad_cfg_o | output | 1 | Last taken ratio code was invalid |
| res_o | output | 128 | Eight 16-bit averaged results, same lane layout |

## Verification
A wrong round counter or a wrong latched shift shows up in the very conversion it affects: the number of trigger pulses per group is off, and the averaged lanes are scaled wrongly as soon as busy drops. A group flag or pending flag left set by mistake shows up as a missing trigger, as busy failing to rise, or as lanes that are overwritten when they should be kept. For that reason, every conversion checks the trigger counts together with all eight lanes. The split-start, timeout and ignored-edge cases are each run once, straight after a conversion whose values are known.

// File: rtl/os_seq_pkg.sv
package os_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } seq_st_t;

  localparam logic [2:0] OS_CODE_BAD = 3'b111;

  // Ratio code to shift amount; the invalid code falls back to no averaging.
  function automatic logic [2:0] os_code_to_shift(input logic [2:0] code);
    return (code == OS_CODE_BAD) ? 3'd0 : code;
  endfunction

endpackage

// File: rtl/os_edge_det.sv
module os_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q_r;
    always_ff @(posedge clk) begin
      if (rst) q_r <= 1'b0;
      else     q_r <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~q_r;
  end

endmodule

// File: rtl/os_chan_acc.sv
module os_chan_acc #(
  parameter int SMP_W = 16,
  parameter int ACC_W = 23,
  parameter int SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             commit_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [SMP_W-1:0] res_o
);

  localparam int EXT_W = ACC_W - SMP_W;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] smp_ext;
  logic signed [ACC_W-1:0] avg;

  assign smp_ext = {{EXT_W{smp_i[SMP_W-1]}}, smp_i};
  assign avg     = acc_q >>> shift_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      res_o <= '0;
    end else if (commit_i) begin
      res_o <= avg[SMP_W-1:0];
      acc_q <= '0;
    end else if (add_i) begin
      acc_q <= acc_q + smp_ext;
    end
  end

endmodule

// File: rtl/os_seq_ctrl.sv
module os_seq_ctrl
  import os_seq_pkg::*;
#(
  parameter int WAIT_LIMIT = 256,
  parameter int MAX_SHIFT  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rise_i,
  input  logic [2:0] os_sel_i,
  input  logic       valid_a_i,
  input  logic       valid_b_i,
  output logic       trig_a_o,
  output logic       trig_b_o,
  output logic       busy_o,
  output logic       bad_cfg_o,
  output logic [2:0] os_shift_o,
  output logic       add_a_o,
  output logic       add_b_o,
  output logic       commit_a_o,
  output logic       commit_b_o
);

  localparam int RND_W = MAX_SHIFT + 1;
  localparam int WT_W  = $clog2(WAIT_LIMIT + 1);

  seq_st_t          st_q;
  logic             pend_a_q, pend_b_q;
  logic             take_a_q, take_b_q;
  logic [RND_W-1:0] rnd_q;
  logic [WT_W-1:0]  wt_q;
  logic [RND_W-1:0] last_rnd;
  logic             round_done, conv_done;
  logic             rise_a, rise_b;

  assign rise_a     = rise_i[0];
  assign rise_b     = rise_i[1];
  assign last_rnd   = (RND_W'(1) << os_shift_o) - RND_W'(1);
  assign round_done = (st_q == ST_RUN) && !pend_a_q && !pend_b_q;
  assign conv_done  = round_done && (rnd_q == last_rnd);
  assign commit_a_o = conv_done && take_a_q;
  assign commit_b_o = conv_done && take_b_q;
  assign add_a_o    = valid_a_i && pend_a_q;
  assign add_b_o    = valid_b_i && pend_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      pend_a_q   <= 1'b0;
      pend_b_q   <= 1'b0;
      take_a_q   <= 1'b0;
      take_b_q   <= 1'b0;
      rnd_q      <= '0;
      wt_q       <= '0;
      trig_a_o   <= 1'b0;
      trig_b_o   <= 1'b0;
      busy_o     <= 1'b0;
      bad_cfg_o  <= 1'b0;
      os_shift_o <= 3'd0;
    end else begin
      trig_a_o <= 1'b0;
      trig_b_o <= 1'b0;
      if (add_a_o) pend_a_q <= 1'b0;
      if (add_b_o) pend_b_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          rnd_q <= '0;
          wt_q  <= '0;
          if (os_shift_o != 3'd0) begin
            if (rise_a) begin
              trig_a_o <= 1'b1; trig_b_o <= 1'b1;
              pend_a_q <= 1'b1; pend_b_q <= 1'b1;
              take_a_q <= 1'b1; take_b_q <= 1'b1;
              busy_o   <= 1'b1;
              st_q     <= ST_RUN;
            end
          end else if (rise_a && rise_b) begin
            trig_a_o <= 1'b1; trig_b_o <= 1'b1;
            pend_a_q <= 1'b1; pend_b_q <= 1'b1;
            take_a_q <= 1'b1; take_b_q <= 1'b1;
            busy_o   <= 1'b1;
            st_q     <= ST_RUN;
          end else if (rise_a) begin
            trig_a_o <= 1'b1; pend_a_q <= 1'b1;
            take_a_q <= 1'b1; take_b_q <= 1'b0;
            st_q     <= ST_ARM;
          end else if (rise_b) begin
            trig_b_o <= 1'b1; pend_b_q <= 1'b1;
            take_b_q <= 1'b1; take_a_q <= 1'b0;
            st_q     <= ST_ARM;
          end
        end
        ST_ARM: begin
          wt_q <= wt_q + WT_W'(1);
          if (!take_a_q && rise_a) begin
            trig_a_o <= 1'b1; pend_a_q <= 1'b1; take_a_q <= 1'b1;
            busy_o   <= 1'b1; st_q     <= ST_RUN;
          end else if (!take_b_q && rise_b) begin
            trig_b_o <= 1'b1; pend_b_q <= 1'b1; take_b_q <= 1'b1;
            busy_o   <= 1'b1; st_q     <= ST_RUN;
          end else if (wt_q == WT_W'(WAIT_LIMIT - 1)) begin
            busy_o <= 1'b1;
            st_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (conv_done) begin
            busy_o     <= 1'b0;
            os_shift_o <= os_code_to_shift(os_sel_i);
            bad_cfg_o  <= (os_sel_i == OS_CODE_BAD);
            take_a_q   <= 1'b0;
            take_b_q   <= 1'b0;
            st_q       <= ST_IDLE;
          end else if (round_done) begin
            rnd_q    <= rnd_q + RND_W'(1);
            trig_a_o <= take_a_q; pend_a_q <= take_a_q;
            trig_b_o <= take_b_q; pend_b_q <= take_b_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/os_conv_seq.sv
module os_conv_seq #(
  parameter int NCH        = 8,
  parameter int SMP_W      = 16,
  parameter int ACC_W      = 23,
  parameter int WAIT_LIMIT = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_a_i,
  input  logic                 start_b_i,
  input  logic [2:0]           os_sel_i,
  input  logic                 smp_valid_a_i,
  input  logic                 smp_valid_b_i,
  input  logic [NCH*SMP_W-1:0] smp_data_i,
  output logic                 trig_a_o,
  output logic                 trig_b_o,
  output logic                 busy_o,
  output logic                 bad_cfg_o,
  output logic [NCH*SMP_W-1:0] res_o
);

  localparam int GRP = NCH / 2;

  logic [1:0] rise;
  logic [2:0] os_shift;
  logic       add_a, add_b, commit_a, commit_b;

  os_edge_det #(.N(2)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  ({start_b_i, start_a_i}),
    .rise_o (rise)
  );

  os_seq_ctrl #(.WAIT_LIMIT(WAIT_LIMIT), .MAX_SHIFT(6)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise),
    .os_sel_i   (os_sel_i),
    .valid_a_i  (smp_valid_a_i),
    .valid_b_i  (smp_valid_b_i),
    .trig_a_o   (trig_a_o),
    .trig_b_o   (trig_b_o),
    .busy_o     (busy_o),
    .bad_cfg_o  (bad_cfg_o),
    .os_shift_o (os_shift),
    .add_a_o    (add_a),
    .add_b_o    (add_b),
    .commit_a_o (commit_a),
    .commit_b_o (commit_b)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_add, ch_commit;
    if (c < GRP) begin : g_a
      assign ch_add    = add_a;
      assign ch_commit = commit_a;
    end else begin : g_b
      assign ch_add    = add_b;
      assign ch_commit = commit_b;
    end
    os_chan_acc #(.SMP_W(SMP_W), .ACC_W(ACC_W), .SH_W(3)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .add_i    (ch_add),
      .smp_i    (smp_data_i[c*SMP_W +: SMP_W]),
      .commit_i (ch_commit),
      .shift_i  (os_shift),
      .res_o    (res_o[c*SMP_W +: SMP_W])
    );
  end

endmodule

// File: rtl/os_conv_seq_chk.sv
module os_conv_seq_chk #(
  parameter int RES_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_o,
  input logic             trig_a_o,
  input logic             trig_b_o,
  input logic             bad_cfg_o,
  input logic [2:0]       os_shift,
  input logic [RES_W-1:0] res_o
);

  assert_res_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (res_o != $past(res_o)) |-> $fell(busy_o));

  assert_trig_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    trig_a_o |=> !trig_a_o);

  assert_os_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (trig_a_o && os_shift != 3'd0) |-> trig_b_o);

  assert_os_latch_R3: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy_o) |-> $stable(os_shift));

  assert_bad_cfg_R2: assert property (@(posedge clk) disable iff (rst)
    bad_cfg_o |-> (os_shift == 3'd0));

endmodule

bind os_conv_seq os_conv_seq_chk #(.RES_W(NCH*SMP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy_o    (busy_o),
  .trig_a_o  (trig_a_o),
  .trig_b_o  (trig_b_o),
  .bad_cfg_o (bad_cfg_o),
  .os_shift  (os_shift),
  .res_o     (res_o)
);

// File: tb/os_conv_seq_tb.sv
module os_conv_seq_tb;

  localparam int NCH = 8;
  localparam int W   = 16;
  localparam int WL  = 32;
  localparam int LAT = 3;

  typedef struct packed {
    logic [2:0]         os;
    logic signed [15:0] b0;
    logic signed [15:0] st;
    logic signed [15:0] ds;
  } vec_t;

  localparam vec_t TAB [8] = '{
    '{3'd0,  16'sd100,    16'sd7,     16'sd0},
    '{3'd1, -16'sd5,      16'sd3,     16'sd1},
    '{3'd2,  16'sd1000,  -16'sd250,  -16'sd3},
    '{3'd3, -16'sd32768,  16'sd0,     16'sd0},
    '{3'd4,  16'sd32767, -16'sd1,     16'sd0},
    '{3'd5, -16'sd7,      16'sd2,    -16'sd1},
    '{3'd6,  16'sd20000, -16'sd5000,  16'sd11},
    '{3'd7,  16'sd321,   -16'sd77,    16'sd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_a_i = 1'b0, start_b_i = 1'b0;
  logic [2:0] os_sel_i = 3'd0;
  logic smp_valid_a_i = 1'b0, smp_valid_b_i = 1'b0;
  logic [NCH*W-1:0] smp_data_i = '0;
  logic trig_a_o, trig_b_o, busy_o, bad_cfg_o;
  logic [NCH*W-1:0] res_o;

  int checks = 0, errors = 0;
  int b0 = 0, st = 0, ds = 0;
  int rnd_a = 0, rnd_b = 0, ntrig_a = 0, ntrig_b = 0, cd_a = 0, cd_b = 0;
  int exp_r [NCH];

  always #2.5 clk = ~clk;

  os_conv_seq #(.NCH(NCH), .SMP_W(W), .ACC_W(23), .WAIT_LIMIT(WL)) u_dut (
    .clk(clk), .rst(rst), .start_a_i(start_a_i), .start_b_i(start_b_i),
    .os_sel_i(os_sel_i), .smp_valid_a_i(smp_valid_a_i), .smp_valid_b_i(smp_valid_b_i),
    .smp_data_i(smp_data_i), .trig_a_o(trig_a_o), .trig_b_o(trig_b_o),
    .busy_o(busy_o), .bad_cfg_o(bad_cfg_o), .res_o(res_o)
  );

  function automatic int samp(input int ch, input int r);
    return b0 + ch * st + r * ds;
  endfunction

  function automatic int avg(input int ch, input int sh);
    int s = 0;
    for (int r = 0; r < (1 << sh); r++) s += samp(ch, r);
    return s >>> sh;
  endfunction

  function automatic int lane(input int ch);
    return int'($signed(res_o[ch*W +: W]));
  endfunction

  // Behavioural sample source: answers each trigger LAT cycles later.
  always @(negedge clk) begin
    smp_valid_a_i = 1'b0;
    smp_valid_b_i = 1'b0;
    if (cd_a > 0) begin
      cd_a--;
      if (cd_a == 0) begin
        for (int c = 0; c < NCH/2; c++) smp_data_i[c*W +: W] = W'(samp(c, rnd_a));
        smp_valid_a_i = 1'b1; rnd_a++;
      end
    end
    if (cd_b > 0) begin
      cd_b--;
      if (cd_b == 0) begin
        for (int c = NCH/2; c < NCH; c++) smp_data_i[c*W +: W] = W'(samp(c, rnd_b));
        smp_valid_b_i = 1'b1; rnd_b++;
      end
    end
    if (trig_a_o) begin cd_a = LAT; ntrig_a++; end
    if (trig_b_o) begin cd_b = LAT; ntrig_b++; end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clr_cnt();
    rnd_a = 0; rnd_b = 0; ntrig_a = 0; ntrig_b = 0;
  endtask

  task automatic pulse(input logic a, input logic b);
    @(negedge clk); start_a_i = a; start_b_i = b;
    @(negedge clk); start_a_i = 1'b0; start_b_i = 1'b0;
  endtask

  task automatic wait_done();
    bit seen = 0;
    for (int k = 0; k < 20000; k++) begin
      if (busy_o) begin
        if (!seen) begin
          int same = 1;
          for (int c = 0; c < NCH; c++) if (lane(c) != exp_r[c]) same = 0;
          chk("R5 lanes held while busy", same, 1);
        end
        seen = 1;
      end else if (seen) begin
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic upd(input bit ga, input bit gb, input int sh);
    for (int c = 0; c < NCH; c++)
      if ((c < NCH/2) ? ga : gb) exp_r[c] = avg(c, sh);
  endtask

  task automatic chk_lanes(input string req);
    for (int c = 0; c < NCH; c++) chk(req, lane(c), exp_r[c]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) exp_r[c] = 0;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 trig after reset", int'(trig_a_o | trig_b_o), 0);
    chk("R1 bad_cfg after reset", int'(bad_cfg_o), 0);
    chk("R1 results zero", int'(res_o == '0), 1);
    rst = 1'b0;

    // Priming conversion runs at the reset ratio of 1 (R1).
    b0 = 11; st = -3; ds = 0;
    os_sel_i = TAB[0].os;
    clr_cnt(); pulse(1, 1); wait_done();
    chk("R1 default ratio trig count", ntrig_a, 1);
    upd(1, 1, 0); chk_lanes("R6 priming lanes");

    for (int i = 0; i < 8; i++) begin
      int sh;
      logic [2:0] nxt;
      nxt = (i < 7) ? TAB[i+1].os : 3'd0;
      sh  = (TAB[i].os == 3'd7) ? 0 : int'(TAB[i].os);
      b0 = TAB[i].b0; st = TAB[i].st; ds = TAB[i].ds;
      os_sel_i = nxt;
      clr_cnt(); pulse(1, 1); wait_done();
      chk("R4 trig count group A", ntrig_a, 1 << sh);
      chk("R2 trig count group B", ntrig_b, 1 << sh);
      upd(1, 1, sh); chk_lanes("R6 averaged lanes");
      chk("R2 bad_cfg flag", int'(bad_cfg_o), int'(nxt == 3'd7));
    end

    // R3: the select present at start is not used; only the value at busy fall counts.
    os_sel_i = 3'd3;
    b0 = 50; st = 1; ds = 2;
    clr_cnt(); pulse(1, 1); os_sel_i = 3'd2; wait_done();
    chk("R3 ratio unaffected by mid-idle select", ntrig_a, 1);
    upd(1, 1, 0); chk_lanes("R3 lanes");

    // R10: ratio 4 is latched; a start B edge alone does nothing.
    clr_cnt(); pulse(0, 1); repeat (10) @(negedge clk);
    chk("R10 busy stays low", int'(busy_o), 0);
    chk("R10 no triggers", ntrig_a + ntrig_b, 0);

    // R8: a repeated start during busy in averaging mode adds no trigger.
    os_sel_i = 3'd0;
    b0 = -900; st = 123; ds = -5;
    clr_cnt(); pulse(1, 0); repeat (2) @(negedge clk); pulse(1, 1); wait_done();
    chk("R8 trig count with edge while busy", ntrig_a, 4);
    upd(1, 1, 2); chk_lanes("R8 lanes");

    // R7: split start with ratio 1.
    b0 = 7777; st = -1111; ds = 0;
    clr_cnt(); pulse(1, 0); repeat (6) @(negedge clk);
    chk("R7 busy low with one group", int'(busy_o), 0);
    chk("R7 group B not triggered", ntrig_b, 0);
    pulse(1, 0);
    chk("R8 repeated group A edge ignored", ntrig_a, 1);
    pulse(0, 1); wait_done();
    chk("R7 group B triggered once", ntrig_b, 1);
    upd(1, 1, 0); chk_lanes("R7 split lanes");

    // R9: group A never starts; timeout completes with group B only.
    b0 = -2500; st = 40; ds = 0;
    clr_cnt(); pulse(0, 1); wait_done();
    chk("R9 group A not triggered", ntrig_a, 0);
    upd(0, 1, 0); chk_lanes("R9 lanes after timeout");
    chk("R9 busy low after timeout conversion", int'(busy_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule